// File: doc/BRIEF.md
# Programmable Timer/Counter with External Event Input

This block is a 16-bit timer/counter for an embedded controller. It advances either on every system clock or on each rising edge of an event input. The event input can come from an asynchronous pin or from an internal pulse-width-demodulator signal. The raw source passes through a two-stage synchronizer and an edge detector, so each rising edge advances the count exactly once.

Software reaches four registers through a simple write/read port: the count, two limit values (A and B) and a control word. The output operates in one of two modes:

- **Continuous mode:** the counter alternates between limit A and limit B. The output is low during the A phase and high during the B phase, which gives a waveform with a programmable duty cycle.
- **Single-pulse mode:** the output drops low for one count to limit A, then returns high and the counter stops.

The output-enable is low while reset or bus hold is active, so the pin floats. Counting continues during bus hold.

Top module: `tmr_unit`

## Requirements
- R1: While `rst_n` is low, the count, both limits and the control word read as zero, `tmr_out` is 1 and `tmr_oe` is 0.
- R2: With the control bit `en` (bit 0) set and `ext_sel` (bit 1) clear, the count rises by one on every clock.
- R3: With `ext_sel` set, a rising edge of the selected event source that is first sampled at clock edge k updates the count at clock edge k+2. Each edge counts exactly once.
- R4: A steady level or a falling edge on the selected event source leaves the count unchanged.
- R5: When control bit 3 (`pwd_sel`) is set, `pwd_in` is the event source and `ext_in` is ignored.
- R6: When control bit 4 (`pin_gpio`) is set and `pwd_sel` is clear, `ext_in` is ignored and the source is held high.
- R7: When control bit 2 (`cont`) is set, counting to the limit wraps the count to zero and switches phase. Phase A uses limit A and sets `tmr_out`=0. Phase B uses limit B and sets `tmr_out`=1. Each phase therefore lasts limit+1 counted events.
- R8: When `cont` is clear, `tmr_out` is 0 while enabled and counting toward limit A. On the match, the count returns to 0, `tmr_out` returns to 1, and further events are ignored until the control word is written again.
- R9: When `en` is clear, the count holds its value.
- R10: A write to the count register (address 0) loads the new value at the next clock edge. That write takes precedence over the count event in the same cycle.
- R11: `tmr_oe` is 0 while `bus_hold` is high and 1 otherwise after reset. `bus_hold` does not stop counting.
- R12: A write to the control word (address 3) returns the phase to A and re-arms single-pulse mode. The count is not advanced in that cycle.
- R13: Reads return count, limit A, limit B and the zero-extended control word at addresses 0, 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| bus_hold | input | 1 | Bus hold; floats the timer output |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| ext_in | input | 1 | Asynchronous external event pin |
| pwd_in | input | 1 | Internal demodulator event signal |
| tmr_out | output | 1 | Timer waveform output |
| tmr_oe | output | 1 | Output enable for `tmr_out` |

## Verification
The hardest situation to reach is a rising edge on the selected source that coincides with a limit match or with a register write. The edge has to be launched two clocks ahead, because of the synchronizer, so that it lands in the cycle where it matters.

The stimulus toggles the event pin with periods that are not multiples of the phase length, and it issues count and control writes while edges are in flight. The behavioural model carries its own delay queue for the synchronized source. The stimulus also switches between the pin, the demodulator and the forced-high source while the other inputs keep moving. Any leak of an unselected source then shows up as a count mismatch on the next compared cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] ADR_CNT  = 2'd0;
  localparam logic [1:0] ADR_LIMA = 2'd1;
  localparam logic [1:0] ADR_LIMB = 2'd2;
  localparam logic [1:0] ADR_CTL  = 2'd3;
  localparam int CTL_W = 5;

  typedef struct packed {
    logic pin_gpio;
    logic pwd_sel;
    logic cont;
    logic ext_sel;
    logic en;
  } ctl_t;
endpackage

// File: rtl/tmr_insync.sv
module tmr_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic rise
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d[0] = raw;
    for (int i = 1; i <= LAST; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign rise = chain_q[LAST-1] & ~chain_q[LAST];

  a_r3_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] lim_a,
  output logic [CNT_W-1:0] lim_b,
  output tmr_pkg::ctl_t    ctl,
  output logic             cnt_wr,
  output logic             ctl_wr
);
  import tmr_pkg::*;

  logic lima_wr, limb_wr;

  always_comb begin
    cnt_wr  = wr_en && (wr_addr == ADR_CNT);
    lima_wr = wr_en && (wr_addr == ADR_LIMA);
    limb_wr = wr_en && (wr_addr == ADR_LIMB);
    ctl_wr  = wr_en && (wr_addr == ADR_CTL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_a <= '0;
      lim_b <= '0;
      ctl   <= '0;
    end else begin
      if (lima_wr) lim_a <= wr_data;
      if (limb_wr) lim_b <= wr_data;
      if (ctl_wr)  ctl   <= ctl_t'(wr_data[CTL_W-1:0]);
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  tmr_pkg::ctl_t    ctl,
  input  logic [CNT_W-1:0] lim_a,
  input  logic [CNT_W-1:0] lim_b,
  input  logic             cnt_wr,
  input  logic             ctl_wr,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] count,
  output logic             wave
);
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic ph_q, ph_d, done_q, done_d;
  logic tick, at_lim;

  always_comb begin
    lim    = ph_q ? lim_b : lim_a;
    at_lim = (cnt_q == lim);
    tick   = ctl.en & (ctl.ext_sel ? evt : 1'b1) & ~done_q & ~cnt_wr & ~ctl_wr;
    cnt_d  = cnt_q;
    ph_d   = ph_q;
    done_d = done_q;
    if (cnt_wr) begin
      cnt_d = ld_val;
    end else if (ctl_wr) begin
      ph_d   = 1'b0;
      done_d = 1'b0;
    end else if (tick) begin
      if (at_lim) begin
        cnt_d = '0;
        if (ctl.cont) ph_d   = ~ph_q;
        else          done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ph_q   <= ph_d;
      done_q <= done_d;
    end
  end

  assign count = cnt_q;
  assign wave  = ctl.cont ? ph_q : ~(ctl.en & ~done_q);

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !at_lim |=> (cnt_q - $past(cnt_q)) == CNT_W'(1));
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick && at_lim |=> cnt_q == '0);
  a_r7_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    tick && at_lim && ctl.cont |=> ph_q != $past(ph_q));
  a_r8_stays_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !ctl_wr && !cnt_wr |=> done_q && $stable(cnt_q));
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en && !cnt_wr |=> $stable(cnt_q));
  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(ld_val));
  a_r12_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !ph_q && !done_q);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_hold,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             ext_in,
  input  logic             pwd_in,
  output logic             tmr_out,
  output logic             tmr_oe
);
  import tmr_pkg::*;

  ctl_t             ctl;
  logic [CNT_W-1:0] lim_a, lim_b, count;
  logic             cnt_wr, ctl_wr, src_raw, evt, alive_q;

  always_comb begin
    if (ctl.pwd_sel)       src_raw = pwd_in;
    else if (ctl.pin_gpio) src_raw = 1'b1;
    else                   src_raw = ext_in;
  end

  tmr_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(src_raw), .rise(evt)
  );

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lim_a(lim_a), .lim_b(lim_b), .ctl(ctl),
    .cnt_wr(cnt_wr), .ctl_wr(ctl_wr)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .evt(evt), .ctl(ctl), .lim_a(lim_a),
    .lim_b(lim_b), .cnt_wr(cnt_wr), .ctl_wr(ctl_wr), .ld_val(wr_data),
    .count(count), .wave(tmr_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alive_q <= 1'b0;
    else        alive_q <= 1'b1;
  end

  assign tmr_oe = alive_q & ~bus_hold;

  always_comb begin
    case (rd_addr)
      ADR_CNT:  rd_data = count;
      ADR_LIMA: rd_data = lim_a;
      ADR_LIMB: rd_data = lim_b;
      default:  rd_data = CNT_W'(ctl);
    endcase
  end

  a_r11_alive_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> alive_q);
endmodule

// File: tb/test_tmr_unit.sv
module test_tmr_unit;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, bus_hold, wr_en, ext_in, pwd_in;
  logic [1:0] wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic tmr_out, tmr_oe;

  int n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit done_flag = 0;

  // reference model state
  int m_cnt, m_la, m_lb, m_ctl, m_ph, m_done, m_alive;
  int m_sync[$];

  always #(PERIOD/2) clk = ~clk;

  tmr_unit i_tmr_unit (
    .clk(clk), .rst_n(rst_n), .bus_hold(bus_hold), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .ext_in(ext_in), .pwd_in(pwd_in),
    .tmr_out(tmr_out), .tmr_oe(tmr_oe)
  );

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    m_cnt = 0; m_la = 0; m_lb = 0; m_ctl = 0; m_ph = 0; m_done = 0; m_alive = 0;
    m_sync = '{1, 1, 1};
  endfunction

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      int src, edge_seen, tick, lim;
      bit en, xs, cont, pwd, gp, wcnt, wctl;
      en = m_ctl[0]; xs = m_ctl[1]; cont = m_ctl[2]; pwd = m_ctl[3]; gp = m_ctl[4];
      src = pwd ? pwd_in : (gp ? 1 : ext_in);
      // m_sync[0] newest sample; [1] synchronized; [2] previous synchronized
      edge_seen = (m_sync[1] == 1 && m_sync[2] == 0);
      wcnt = wr_en && wr_addr == 0;
      wctl = wr_en && wr_addr == 3;
      tick = en && (xs ? edge_seen : 1) && !m_done && !wcnt && !wctl;
      lim = m_ph ? m_lb : m_la;
      if (wcnt) m_cnt = wr_data;
      else if (wctl) begin m_ph = 0; m_done = 0; end
      else if (tick) begin
        if (m_cnt == lim) begin
          m_cnt = 0;
          if (cont) m_ph = 1 - m_ph; else m_done = 1;
        end else m_cnt = (m_cnt + 1) & 16'hFFFF;
      end
      if (wr_en && wr_addr == 1) m_la = wr_data;
      if (wr_en && wr_addr == 2) m_lb = wr_data;
      if (wctl) m_ctl = wr_data & 5'h1F;
      m_sync.push_front(src);
      void'(m_sync.pop_back());
      m_alive = 1;
    end
    #(PERIOD/4);
    if (!done_flag) begin
      int exp_rd, exp_out;
      case (rd_addr)
        2'd0: exp_rd = m_cnt;
        2'd1: exp_rd = m_la;
        2'd2: exp_rd = m_lb;
        default: exp_rd = m_ctl;
      endcase
      exp_out = m_ctl[2] ? m_ph : !(m_ctl[0] && !m_done);
      chk("rd_data", int'(rd_data), exp_rd);
      chk("tmr_out", int'(tmr_out), exp_out);
      chk("tmr_oe", int'(tmr_oe), (m_alive && !bus_hold) ? 1 : 0);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic toggle_ext(int hi, int lo, int reps);
    for (int r = 0; r < reps; r++) begin
      ext_in = 1'b1; idle(hi);
      ext_in = 1'b0; idle(lo);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_hold = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = '0;
    rd_addr = 2'd0; ext_in = 1'b0; pwd_in = 1'b0;
    cur_req = "R1"; idle(4);
    rst_n = 1'b1;
    cur_req = "R2"; wr(2'd1, 16'd5); wr(2'd2, 16'd3);
    wr(2'd3, 16'h05);            // en + cont, internal clocks
    cur_req = "R7"; idle(30);
    cur_req = "R9"; wr(2'd3, 16'h04); idle(6);
    cur_req = "R10"; wr(2'd3, 16'h05); idle(3); wr(2'd0, 16'd1); idle(4); wr(2'd0, 16'd0);
    idle(5);
    cur_req = "R8"; wr(2'd1, 16'd4); wr(2'd3, 16'h01); idle(14);
    cur_req = "R12"; wr(2'd3, 16'h01); idle(10);
    cur_req = "R3"; wr(2'd1, 16'd2); wr(2'd2, 16'd2); wr(2'd3, 16'h07);
    toggle_ext(3, 3, 8); toggle_ext(1, 2, 6); toggle_ext(2, 1, 6);
    cur_req = "R4"; ext_in = 1'b1; idle(12); ext_in = 1'b0; idle(8);
    cur_req = "R5"; wr(2'd3, 16'h0F);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); ext_in = ~ext_in; if (i % 4 == 0) pwd_in = ~pwd_in;
    end
    cur_req = "R6"; wr(2'd3, 16'h17); toggle_ext(1, 1, 15);
    cur_req = "R11"; wr(2'd3, 16'h05); idle(3);
    bus_hold = 1'b1; idle(7); bus_hold = 1'b0; idle(2); bus_hold = 1'b1; idle(1); bus_hold = 1'b0;
    idle(3);
    cur_req = "R13";
    for (int a = 0; a < 4; a++) begin @(negedge clk); rd_addr = 2'(a); idle(2); end
    rd_addr = 2'd0;
    cur_req = "R1"; @(negedge clk); rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(3);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule